// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

This block is a memory-mapped event timer for a system timebase. A single 64-bit main counter advances by one on every clock while a global run bit is set, and a small set of comparator channels (three by default) watch it. Each channel can raise its event once when the counter reaches a programmed value (one-shot) or keep raising it at a fixed interval by adding an increment to its comparator after every match (periodic). A channel can also ignore the upper 32 bits of both the counter and its comparator.

Software uses a plain 32-bit register port: an address, a write strobe, write data and a combinational read-data return. Two read-only registers describe the block: one holds the channel count and the legacy capability, and the other holds the tick period in femtoseconds. Each channel keeps a sticky event flag, and a channel's interrupt line is high while its flag and its interrupt enable are both set. A legacy steering mode moves channel 0 onto a fixed system-tick interrupt pin and channel 1 onto a fixed real-time-clock interrupt pin.

Top module: `evt_timer`

## Requirements
- R1: The main counter (low word 0x0F0, high word 0x0F4) rises by exactly one per clock while the run bit (bit 0 of the global control register at 0x010) is 1, and it holds its value while that bit is 0.
- R2: Both counter words can be written, whether the counter runs or not. A write replaces only the addressed 32-bit half, and the written value reads back.
- R3: Register 0x000 reads (NCH-1) in bits [12:8] and 1 in bit 15, with all other bits 0. Register 0x004 reads the PERIOD_FS parameter. Writes to either register change nothing.
- R4: A channel in one-shot mode sets its status bit (bit n of 0x020 for channel n) at the clock edge at which the counter value equals the comparator. It leaves the comparator unchanged, so the channel fires only once.
- R5: A channel in periodic mode (config bit 3) sets its status bit at every match and adds its stored increment to the comparator at that same edge, so it fires at counter values K, K+P, K+2P, and so on.
- R6: Writing a channel config (0x100+0x20·n) with bit 6 set starts the set-value sequence. The next write to that channel's comparator low word (0x108+0x20·n) loads the compare value, and the write after that loads the 32-bit increment. Config bit 6 reads 1 until the second write and 0 afterwards. Outside the sequence, a comparator low-word write loads only the compare value.
- R7: With config bit 8 set, a channel compares only the low 32 bits of the counter and of the comparator, so the comparator high word (0x10C+0x20·n) has no effect on matching.
- R8: Writing 1 to a bit of 0x020 clears that status bit, and writing 0 leaves it unchanged. If a match occurs at the same edge as the clear, the bit stays set.
- R9: With legacy mode off, irq_o[n] is high exactly when channel n's status bit and its interrupt enable (config bit 2) are both 1.
- R10: With legacy mode on (bit 1 of 0x010), channel 0's interrupt appears on leg_tick_irq_o and channel 1's on leg_rtc_irq_o, while irq_o[0] and irq_o[1] stay low. Channels 2 and above still drive their own irq_o bits. With legacy mode off, both legacy pins are low.
- R11: Config bits [13:9] form a route field that stores and reads back any written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe, one write per clock |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | NCH | Per-channel interrupt lines |
| leg_tick_irq_o | output | 1 | Legacy system-tick interrupt (channel 0 in legacy mode) |
| leg_rtc_irq_o | output | 1 | Legacy real-time-clock interrupt (channel 1 in legacy mode) |

## Verification
The bench sweeps the counter cycle by cycle through one-shot, periodic and low-word-only matches, and it predicts each status bit from the counter value it reads. A comparator that is off by one edge, or that fails to advance after a periodic match, shows up as a status bit on the wrong cycle or as a wrong final comparator value. The set-value sequence is checked by reading back both the comparator and the later firing interval. If the second write were routed to the comparator, the channel would fire at the increment value instead of the compare value. An increment of one, with a clear written every cycle, tests whether a new match wins over a simultaneous clear. The legacy steering test confirms that channels 0 and 1 leave their own lines while channel 2 does not.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 64;

    localparam logic [ADDR_W-1:0] A_CAPS  = 12'h000;
    localparam logic [ADDR_W-1:0] A_TICK  = 12'h004;
    localparam logic [ADDR_W-1:0] A_CTRL  = 12'h010;
    localparam logic [ADDR_W-1:0] A_FLAGS = 12'h020;
    localparam logic [ADDR_W-1:0] A_CNTL  = 12'h0F0;
    localparam logic [ADDR_W-1:0] A_CNTH  = 12'h0F4;

    localparam logic [4:0] OFF_CFG  = 5'h00;
    localparam logic [4:0] OFF_CMPL = 5'h08;
    localparam logic [4:0] OFF_CMPH = 5'h0C;

    localparam int B_IE    = 2;
    localparam int B_PER   = 3;
    localparam int B_SV    = 6;
    localparam int B_M32   = 8;
    localparam int B_RT    = 9;
    localparam int RT_W    = 5;

    typedef enum logic [1:0] {SV_IDLE, SV_CMP, SV_INC} sv_e;
endpackage

// File: rtl/evt_chan.sv
module evt_chan
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cfg_we_i,
    input  logic              cmpl_we_i,
    input  logic              cmph_we_i,
    input  logic              clr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              st_o,
    output logic              irq_o,
    output logic [DATA_W-1:0] cfg_o,
    output logic [CNT_W-1:0]  cmp_o
);
    typedef struct packed {
        logic             ie;
        logic             per;
        logic             m32;
        logic [RT_W-1:0]  route;
        sv_e              sv;
        logic [CNT_W-1:0] cmp;
        logic [31:0]      inc;
        logic             st;
    } chan_s;

    chan_s q, d;
    logic  hit, fire;

    always_comb begin
        d    = q;
        hit  = q.m32 ? (cnt_i[31:0] == q.cmp[31:0]) : (cnt_i == q.cmp);
        fire = run_i && hit;
        if (fire && q.per) begin
            if (q.m32) d.cmp[31:0] = q.cmp[31:0] + q.inc;
            else       d.cmp       = q.cmp + {32'b0, q.inc};
        end
        if (clr_i) d.st = 1'b0;
        if (fire)  d.st = 1'b1;
        if (cfg_we_i) begin
            d.ie    = wdata_i[B_IE];
            d.per   = wdata_i[B_PER];
            d.m32   = wdata_i[B_M32];
            d.route = wdata_i[B_RT +: RT_W];
            if (wdata_i[B_SV]) d.sv = SV_CMP;
        end
        if (cmpl_we_i) begin
            case (q.sv)
                SV_CMP: begin
                    d.cmp[31:0] = wdata_i;
                    d.sv        = SV_INC;
                end
                SV_INC: begin
                    d.inc = wdata_i;
                    d.sv  = SV_IDLE;
                end
                default: d.cmp[31:0] = wdata_i;
            endcase
        end
        if (cmph_we_i) d.cmp[63:32] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ie: 1'b0, per: 1'b0, m32: 1'b0, route: '0,
                           sv: SV_IDLE, cmp: '0, inc: '0, st: 1'b0};
        else        q <= d;
    end

    always_comb begin
        cfg_o                  = '0;
        cfg_o[B_IE]            = q.ie;
        cfg_o[B_PER]           = q.per;
        cfg_o[B_SV]            = (q.sv != SV_IDLE);
        cfg_o[B_M32]           = q.m32;
        cfg_o[B_RT +: RT_W]    = q.route;
    end

    assign st_o  = q.st;
    assign irq_o = q.st && q.ie;
    assign cmp_o = q.cmp;

    p_fire_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> q.st);
    p_oneshot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !q.per && !cmpl_we_i && !cmph_we_i) |=> $stable(q.cmp));
    p_per_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && q.per && !q.m32 && !cmpl_we_i && !cmph_we_i)
        |=> q.cmp == $past(q.cmp) + {32'b0, $past(q.inc)});
    p_sv_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sv == SV_INC && cmpl_we_i && !cfg_we_i) |=> q.sv == SV_IDLE);
    p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fire) |=> !q.st);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int          NCH       = 3,
    parameter logic [31:0] PERIOD_FS = 32'd100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NCH-1:0]    irq_o,
    output logic              leg_tick_irq_o,
    output logic              leg_rtc_irq_o
);
    localparam logic [4:0] NCH_M1 = 5'(NCH - 1);
    localparam logic [DATA_W-1:0] CAPS_VAL = (32'(NCH_M1) << 8) | (32'd1 << 15);

    typedef struct packed {
        logic             run;
        logic             leg;
        logic [CNT_W-1:0] cnt;
    } top_s;

    top_s q, d;

    logic             chan_sel;
    logic [2:0]       ch_idx;
    logic [4:0]       ch_off;
    logic             cnt_we;
    logic [NCH-1:0]   st, ch_irq;
    logic [DATA_W-1:0] ch_cfg [NCH];
    logic [CNT_W-1:0]  ch_cmp [NCH];

    assign chan_sel = (addr_i[11:8] == 4'h1);
    assign ch_idx   = addr_i[7:5];
    assign ch_off   = addr_i[4:0];
    assign cnt_we   = we_i && (addr_i == A_CNTL || addr_i == A_CNTH);

    always_comb begin
        d = q;
        if (q.run) d.cnt = q.cnt + 64'd1;
        if (we_i) begin
            if (addr_i == A_CTRL) begin
                d.run = wdata_i[0];
                d.leg = wdata_i[1];
            end
            if (addr_i == A_CNTL) d.cnt[31:0]  = wdata_i;
            if (addr_i == A_CNTH) d.cnt[63:32] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel = we_i && chan_sel && (ch_idx == 3'(i));
        evt_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (q.run),
            .cnt_i     (q.cnt),
            .cfg_we_i  (sel && ch_off == OFF_CFG),
            .cmpl_we_i (sel && ch_off == OFF_CMPL),
            .cmph_we_i (sel && ch_off == OFF_CMPH),
            .clr_i     (we_i && addr_i == A_FLAGS && wdata_i[i]),
            .wdata_i   (wdata_i),
            .st_o      (st[i]),
            .irq_o     (ch_irq[i]),
            .cfg_o     (ch_cfg[i]),
            .cmp_o     (ch_cmp[i])
        );
        if (i < 2) begin : g_legacy
            assign irq_o[i] = ch_irq[i] && !q.leg;
        end else begin : g_own
            assign irq_o[i] = ch_irq[i];
        end
    end

    assign leg_tick_irq_o = q.leg && ch_irq[0];
    assign leg_rtc_irq_o  = q.leg && ch_irq[1];

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CAPS:  rdata_o = CAPS_VAL;
            A_TICK:  rdata_o = PERIOD_FS;
            A_CTRL:  rdata_o = {30'b0, q.leg, q.run};
            A_FLAGS: rdata_o[NCH-1:0] = st;
            A_CNTL:  rdata_o = q.cnt[31:0];
            A_CNTH:  rdata_o = q.cnt[63:32];
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (chan_sel && ch_idx == 3'(i)) begin
                        if (ch_off == OFF_CFG)  rdata_o = ch_cfg[i];
                        if (ch_off == OFF_CMPL) rdata_o = ch_cmp[i][31:0];
                        if (ch_off == OFF_CMPH) rdata_o = ch_cmp[i][63:32];
                    end
                end
            end
        endcase
    end

    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.run && !cnt_we) |=> $stable(q.cnt));
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && !cnt_we) |=> q.cnt == $past(q.cnt) + 64'd1);
    p_leg_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.leg |-> (irq_o[1:0] == 2'b00));
    p_leg_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !q.leg |-> (!leg_tick_irq_o && !leg_rtc_irq_o));
endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
    localparam int          NCH = 3;
    localparam logic [31:0] PFS = 32'd69_841_279;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NCH-1:0] irq;
    logic        ltk, lrt;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_timer #(.NCH(NCH), .PERIOD_FS(PFS)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .leg_tick_irq_o(ltk), .leg_rtc_irq_o(lrt)
    );

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] v);
        addr = a; wdata = v; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic setcnt(logic [31:0] lo);
        wr(12'h010, 32'h0);
        wr(12'h0F0, lo);
        wr(12'h0F4, 32'h0);
        wr(12'h020, 32'h7);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c, s, cf;
        int fires;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h0F0, v); chk("R1 reset cnt", v, 0);
        rd(12'h010, v); chk("R1 reset ctrl", v, 0);
        rd(12'h020, v); chk("R8 reset flags", v, 0);
        chk("R9 reset irq", {61'b0, irq}, 0);

        // R3 capability and period
        rd(12'h000, v); chk("R3 caps", v, ((NCH - 1) << 8) | (1 << 15));
        rd(12'h004, v); chk("R3 period", v, PFS);
        wr(12'h000, 32'hFFFF_FFFF); wr(12'h004, 32'h0);
        rd(12'h000, v); chk("R3 caps after write", v, ((NCH - 1) << 8) | (1 << 15));
        rd(12'h004, v); chk("R3 period after write", v, PFS);

        // R2 counter halves while stopped, R1 hold
        wr(12'h0F0, 32'h1234_5678); wr(12'h0F4, 32'h0000_0009);
        repeat (5) @(negedge clk);
        rd(12'h0F0, v); chk("R2 cnt low", v, 32'h1234_5678);
        rd(12'h0F4, v); chk("R2 cnt high", v, 32'h9);

        // R1 counting sweep
        setcnt(32'h0);
        wr(12'h010, 32'h1);
        for (int n = 0; n < 20; n++) begin
            rd(12'h0F0, v); chk("R1 count step", v, n);
            @(negedge clk);
        end
        // R2 write while running
        wr(12'h0F0, 32'h100);
        rd(12'h0F0, v); chk("R2 write while running", v, 32'h100);

        // R4 one-shot on channel 0, K=10
        setcnt(32'h0);
        wr(12'h100, 32'h4);
        wr(12'h108, 32'd10);
        wr(12'h10C, 32'h0);
        wr(12'h010, 32'h1);
        for (int n = 0; n < 30; n++) begin
            rd(12'h0F0, c); rd(12'h020, s);
            chk("R4 one-shot flag", s[0], (c > 10) ? 1 : 0);
            chk("R9 irq follows flag", irq[0], s[0]);
            @(negedge clk);
        end
        rd(12'h108, v); chk("R4 comparator held", v, 10);

        // R6 set-value handshake and R5 periodic on channel 1, K=5 P=7
        setcnt(32'h0);
        wr(12'h120, 32'h4C);
        rd(12'h120, v); chk("R6 set-value pending", v[6], 1);
        wr(12'h128, 32'd5);
        rd(12'h120, v); chk("R6 still pending", v[6], 1);
        wr(12'h128, 32'd7);
        rd(12'h120, v); chk("R6 self-clear", v[6], 0);
        rd(12'h128, v); chk("R6 compare loaded", v, 5);
        wr(12'h010, 32'h1);
        for (int n = 0; n < 40; n++) begin
            rd(12'h0F0, c); rd(12'h020, s);
            chk("R5 periodic flag", s[1],
                (c >= 6 && ((c - 6) % 7) == 0) ? 1 : 0);
            wr(12'h020, 32'h7);
        end
        wr(12'h010, 32'h0);
        rd(12'h0F0, cf);
        fires = (cf - 1 >= 5) ? ((cf - 1 - 5) / 7 + 1) : 0;
        rd(12'h128, v); chk("R5 comparator advanced", v, 5 + 7 * fires);

        // R8 match wins over clear: channel 2, K=3 P=1
        setcnt(32'h0);
        wr(12'h140, 32'h4C);
        wr(12'h148, 32'd3);
        wr(12'h148, 32'd1);
        wr(12'h010, 32'h1);
        for (int n = 0; n < 10; n++) begin
            rd(12'h0F0, c); rd(12'h020, s);
            chk("R8 set wins", s[2], (c >= 4) ? 1 : 0);
            wr(12'h020, 32'h7);
        end
        wr(12'h010, 32'h0);
        wr(12'h140, 32'h0);
        wr(12'h020, 32'h7);
        rd(12'h020, v); chk("R8 clear when idle", v[2], 0);

        // R7 32-bit mode on channel 0 with nonzero compare high word
        setcnt(32'h0);
        wr(12'h100, 32'h104);
        wr(12'h108, 32'd20);
        wr(12'h10C, 32'hAB);
        wr(12'h010, 32'h1);
        repeat (30) @(negedge clk);
        rd(12'h020, v); chk("R7 low-word match", v[0], 1);
        setcnt(32'h0);
        wr(12'h100, 32'h004);
        wr(12'h010, 32'h1);
        repeat (30) @(negedge clk);
        rd(12'h020, v); chk("R7 full-width no match", v[0], 0);

        // R9 enable gating and R10 legacy steering
        setcnt(32'h0);
        wr(12'h100, 32'h0);
        wr(12'h108, 32'd2);
        wr(12'h10C, 32'h0);
        wr(12'h120, 32'h4);
        wr(12'h128, 32'd2);
        wr(12'h140, 32'h4);
        wr(12'h148, 32'd2);
        wr(12'h14C, 32'h0);
        wr(12'h010, 32'h1);
        repeat (6) @(negedge clk);
        wr(12'h010, 32'h0);
        rd(12'h020, v); chk("R9 all flags set", v[2:0], 3'b111);
        chk("R9 disabled ch0 quiet", irq[0], 0);
        chk("R9 enabled ch1 high", irq[1], 1);
        wr(12'h100, 32'h4);
        wr(12'h010, 32'h2);
        chk("R10 own lines low", {62'b0, irq[1:0]}, 0);
        chk("R10 tick pin", ltk, 1);
        chk("R10 rtc pin", lrt, 1);
        chk("R10 ch2 own line", irq[2], 1);
        wr(12'h010, 32'h0);
        chk("R10 back to own lines", {61'b0, irq}, 3'b111);
        chk("R10 legacy pins low", {62'b0, ltk, lrt}, 0);

        // R11 route field read-back
        wr(12'h140, 32'h15 << 9);
        rd(12'h140, v); chk("R11 route", v[13:9], 5'h15);
        wr(12'h140, 32'h0A << 9);
        rd(12'h140, v); chk("R11 route second", v[13:9], 5'h0A);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule